// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block holds a small set of finished translations from virtual page number to physical frame number. Each translation is tagged with the page number and an address-space identifier (ASID). Because the ASID is part of the tag, entries that belong to several page-table trees can live side by side, and a context switch does not have to empty the buffer. Any slot can hold any translation. A lookup compares the request against every valid slot in parallel. The outcome is registered, so it appears one cycle after the request. A hit returns the full physical address, made from the stored frame with the page offset of the request placed below it. A miss is reported so that an external page-table walker can fetch the translation and write it back through the refill port.

Three invalidation commands are available. The first clears every slot. The second clears only the slots of one ASID, which is needed before that ID is given to another address space. The third clears the slots whose page number lies inside an inclusive range. When a refill needs a slot, an empty slot is used first. If there is none, the least recently used slot is replaced, and the recency order is tracked with one age counter per slot.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is empty, `rsp_valid` is low, and the first lookup reports a miss.
- R2: A request with `lk_valid` high produces `rsp_valid` high on the next clock edge, together with exactly one of `rsp_hit` / `rsp_miss`. When there was no request in the previous cycle, all three are low.
- R3: A hit requires a slot whose page number and ASID both equal the request. `rsp_paddr` is then `{frame, lk_vaddr[OFF_W-1:0]}`, with the page offset taking no part in the match.
- R4: When no slot matches, including the case of the same page number under a different ASID, `rsp_miss` is high and `rsp_paddr` is zero.
- R5: A refill whose page number and ASID match a valid slot rewrites that slot's frame. It does not occupy a second slot.
- R6: A refill with no matching slot takes the lowest-numbered empty slot, if any slot is empty.
- R7: When all slots are full, a refill replaces the slot that has gone longest without a refill or a lookup hit. Both a refill and a lookup hit make their slot the most recent.
- R8: `inv_kind` = 0 clears every slot. `inv_kind` = 3 changes nothing.
- R9: `inv_kind` = 1 clears every slot whose ASID equals `inv_asid` and leaves all other slots intact.
- R10: `inv_kind` = 2 clears every slot, of any ASID, whose page number p satisfies `inv_lo` <= p <= `inv_hi`.
- R11: A refill presented in the same cycle as `inv_valid` is discarded.
- R12: A lookup in the same cycle as a refill sees the contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address space of the lookup |
| rsp_valid | output | 1 | Registered response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent; a walk is needed |
| rsp_paddr | output | PFN_W+OFF_W | Physical address on a hit, zero otherwise |
| fill_valid | input | 1 | Refill write strobe |
| fill_vpn | input | VPN_W | Page number of the refill |
| fill_asid | input | ASID_W | ASID of the refill |
| fill_pfn | input | PFN_W | Frame number of the refill |
| inv_valid | input | 1 | Invalidation strobe |
| inv_kind | input | 2 | 0 all, 1 by ASID, 2 by page range, 3 none |
| inv_asid | input | ASID_W | ASID for kind 1 |
| inv_lo | input | VPN_W | Lower page bound (inclusive) for kind 2 |
| inv_hi | input | VPN_W | Upper page bound (inclusive) for kind 2 |

## Verification
The bench builds the block with `ENTRIES` = 4 and keeps the widths at their defaults: 36-bit page numbers, 4-bit ASIDs, 40-bit frames and a 12-bit offset. With only four slots, a handful of refills fills the array. That makes replacement order, refill into a freed slot, and rewriting in place observable in short directed sequences. The full-width page numbers and frames still check that the offset is kept in place and that the range bounds are compared at full width.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      KILL_ALL   = 2'd0,
      KILL_ASID  = 2'd1,
      KILL_RANGE = 2'd2,
      KILL_NONE  = 2'd3
   } kill_kind_e;
endpackage

// File: rtl/tlb_tag_array.sv
module tlb_tag_array #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 36,
   parameter int ASID_W  = 4,
   parameter int PFN_W   = 40,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VPN_W-1:0]   q_vpn,
   input  logic [ASID_W-1:0]  q_asid,
   output logic [ENTRIES-1:0] q_hit_vec,
   output logic [PFN_W-1:0]   q_pfn,
   input  logic [VPN_W-1:0]   w_vpn,
   input  logic [ASID_W-1:0]  w_asid,
   output logic [ENTRIES-1:0] w_match_vec,
   input  logic               w_en,
   input  logic [IDX_W-1:0]   w_idx,
   input  logic [PFN_W-1:0]   w_pfn,
   input  logic               k_en,
   input  logic [1:0]         k_kind,
   input  logic [ASID_W-1:0]  k_asid,
   input  logic [VPN_W-1:0]   k_lo,
   input  logic [VPN_W-1:0]   k_hi,
   output logic [ENTRIES-1:0] live_vec
);
   import tlb_pkg::*;

   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [ASID_W-1:0]  asid_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q  [ENTRIES];
   logic [ENTRIES-1:0] live_q;
   logic [ENTRIES-1:0] kill_vec;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic sel_w;
      assign sel_w = w_en && (w_idx == IDX_W'(g));

      assign q_hit_vec[g]   = live_q[g] && (vpn_q[g] == q_vpn) && (asid_q[g] == q_asid);
      assign w_match_vec[g] = live_q[g] && (vpn_q[g] == w_vpn) && (asid_q[g] == w_asid);

      always_comb begin
         kill_vec[g] = 1'b0;
         if (k_en) begin
            unique case (k_kind)
               2'(KILL_ALL):   kill_vec[g] = 1'b1;
               2'(KILL_ASID):  kill_vec[g] = (asid_q[g] == k_asid);
               2'(KILL_RANGE): kill_vec[g] = (vpn_q[g] >= k_lo) && (vpn_q[g] <= k_hi);
               default:        kill_vec[g] = 1'b0;
            endcase
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)           live_q[g] <= 1'b0;
         else if (kill_vec[g]) live_q[g] <= 1'b0;
         else if (sel_w)       live_q[g] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel_w) begin
            vpn_q[g]  <= w_vpn;
            asid_q[g] <= w_asid;
            pfn_q[g]  <= w_pfn;
         end
      end
   end

   always_comb begin
      q_pfn = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (q_hit_vec[i]) q_pfn = q_pfn | pfn_q[i];
   end

   assign live_vec = live_q;

   assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (k_en && k_kind == 2'(KILL_ALL)) |=> (live_vec == '0));

   assert_fill_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (w_en && !k_en) |=> live_vec[$past(w_idx)]);

   assert_asid_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (k_en && k_kind == 2'(KILL_ASID) && !w_en) |=> $past(live_vec & ~kill_vec) == live_vec);
endmodule

// File: rtl/tlb_age_lru.sv
module tlb_age_lru #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               touch_en,
   input  logic [IDX_W-1:0]   touch_idx,
   input  logic [ENTRIES-1:0] live_vec,
   output logic [IDX_W-1:0]   victim_idx
);
   localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0]   age_q [ENTRIES];
   logic [ENTRIES-1:0] oldest_vec;
   logic [IDX_W-1:0]   touched_age;

   assign touched_age = age_q[touch_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
      end else if (touch_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (touch_idx == IDX_W'(i))      age_q[i] <= '0;
            else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_old
      assign oldest_vec[g] = (age_q[g] == OLDEST);
   end

   always_comb begin
      victim_idx = '0;
      if (&live_vec) begin
         for (int i = 0; i < ENTRIES; i++)
            if (oldest_vec[i]) victim_idx = IDX_W'(i);
      end else begin
         for (int i = ENTRIES - 1; i >= 0; i--)
            if (!live_vec[i]) victim_idx = IDX_W'(i);
      end
   end

   assert_single_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest_vec) == 1);

   assert_touch_youngest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> (age_q[$past(touch_idx)] == '0));

   assert_free_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(&live_vec) |-> !live_vec[victim_idx]);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 36,
   parameter int ASID_W  = 4,
   parameter int PFN_W   = 40,
   parameter int OFF_W   = 12,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int VA_W   = VPN_W + OFF_W,
   localparam int PA_W   = PFN_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic [PA_W-1:0]   rsp_paddr,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic              inv_valid,
   input  logic [1:0]        inv_kind,
   input  logic [ASID_W-1:0] inv_asid,
   input  logic [VPN_W-1:0]  inv_lo,
   input  logic [VPN_W-1:0]  inv_hi
);
   if (ENTRIES < 2)  begin : g_bad_entries $error("ENTRIES must be at least 2"); end
   if (VPN_W < 1)    begin : g_bad_vpn     $error("VPN_W must be positive"); end
   if (ASID_W < 1)   begin : g_bad_asid    $error("ASID_W must be positive"); end
   if (PFN_W < 1)    begin : g_bad_pfn     $error("PFN_W must be positive"); end
   if (OFF_W < 1)    begin : g_bad_off     $error("OFF_W must be positive"); end

   logic [VPN_W-1:0]   q_vpn;
   logic [OFF_W-1:0]   q_off;
   logic [ENTRIES-1:0] hit_vec, wmatch_vec, live_vec;
   logic [PFN_W-1:0]   hit_pfn;
   logic [IDX_W-1:0]   victim_idx, w_idx, hit_idx, wmatch_idx;
   logic               any_hit, w_en, touch_en;
   logic [IDX_W-1:0]   touch_idx;

   assign q_vpn = lk_vaddr[VA_W-1:OFF_W];
   assign q_off = lk_vaddr[OFF_W-1:0];

   function automatic logic [IDX_W-1:0] enc(input logic [ENTRIES-1:0] v);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (v[i]) r = IDX_W'(i);
      return r;
   endfunction

   tlb_tag_array #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
   ) u_tags (
      .clk(clk), .rst_n(rst_n),
      .q_vpn(q_vpn), .q_asid(lk_asid), .q_hit_vec(hit_vec), .q_pfn(hit_pfn),
      .w_vpn(fill_vpn), .w_asid(fill_asid), .w_match_vec(wmatch_vec),
      .w_en(w_en), .w_idx(w_idx), .w_pfn(fill_pfn),
      .k_en(inv_valid), .k_kind(inv_kind), .k_asid(inv_asid),
      .k_lo(inv_lo), .k_hi(inv_hi), .live_vec(live_vec)
   );

   tlb_age_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .touch_en(touch_en), .touch_idx(touch_idx),
      .live_vec(live_vec), .victim_idx(victim_idx)
   );

   assign any_hit    = |hit_vec;
   assign hit_idx    = enc(hit_vec);
   assign wmatch_idx = enc(wmatch_vec);
   assign w_en       = fill_valid && !inv_valid;
   assign w_idx      = (|wmatch_vec) ? wmatch_idx : victim_idx;
   assign touch_en   = w_en || (lk_valid && any_hit);
   assign touch_idx  = w_en ? w_idx : hit_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid && any_hit;
         rsp_miss  <= lk_valid && !any_hit;
         rsp_paddr <= (lk_valid && any_hit) ? {hit_pfn, q_off} : '0;
      end
   end

   assert_no_dup_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec) && $onehot0(wmatch_vec));

   assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (rsp_valid && (rsp_hit != rsp_miss)));

   assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));

   assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_paddr == '0));

   assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && any_hit) |=> (rsp_paddr[OFF_W-1:0] == $past(q_off)));

   assert_fill_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && inv_valid && !(|wmatch_vec)) |=> $stable(live_vec) || ($past(live_vec) & ~live_vec) != '0);
endmodule

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
   localparam int N = 4;
   logic clk = 1'b0, rst_n = 1'b0;
   logic lk_valid = 0, fill_valid = 0, inv_valid = 0;
   logic [47:0] lk_vaddr = '0;
   logic [3:0]  lk_asid = '0, fill_asid = '0, inv_asid = '0;
   logic [35:0] fill_vpn = '0, inv_lo = '0, inv_hi = '0;
   logic [39:0] fill_pfn = '0;
   logic [1:0]  inv_kind = '0;
   logic        rsp_valid, rsp_hit, rsp_miss;
   logic [51:0] rsp_paddr;
   int vectors = 0, miscompares = 0;
   bit done = 0;

   always #4 clk = ~clk;

   asid_tlb #(.ENTRIES(N)) u0 (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
      .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_asid(inv_asid),
      .inv_lo(inv_lo), .inv_hi(inv_hi));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(); @(negedge clk); endtask

   task automatic look(input logic [35:0] v, input logic [3:0] a, input logic [11:0] o,
                       input bit eh, input logic [39:0] p, input string req);
      lk_valid = 1; lk_vaddr = {v, o}; lk_asid = a;
      step();
      lk_valid = 0;
      chk({req, " valid"}, 64'(rsp_valid), 64'd1);
      chk({req, " hit"},   64'(rsp_hit),   64'(eh));
      chk({req, " miss"},  64'(rsp_miss),  64'(!eh));
      chk({req, " paddr"}, 64'(rsp_paddr), eh ? 64'({p, o}) : 64'd0);
   endtask

   task automatic fill(input logic [35:0] v, input logic [3:0] a, input logic [39:0] p);
      fill_valid = 1; fill_vpn = v; fill_asid = a; fill_pfn = p;
      step();
      fill_valid = 0;
   endtask

   task automatic inv(input logic [1:0] k, input logic [3:0] a, input logic [35:0] lo, input logic [35:0] hi);
      inv_valid = 1; inv_kind = k; inv_asid = a; inv_lo = lo; inv_hi = hi;
      step();
      inv_valid = 0;
   endtask

   function automatic logic [39:0] pf(input int i); return 40'hA0_0000_0000 + 40'(i * 4099); endfunction

   task automatic t_reset();
      chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      look(36'h0_0000_0000, 4'd0, 12'h000, 0, '0, "R1 first lookup");
   endtask

   task automatic t_basic();
      inv(2'd0, 0, 0, 0);
      fill(36'h1_2345_6789, 4'd3, 40'hAB_CDEF_0123);
      look(36'h1_2345_6789, 4'd3, 12'hABC, 1, 40'hAB_CDEF_0123, "R3 hit paddr");
      look(36'h1_2345_6789, 4'd3, 12'h001, 1, 40'hAB_CDEF_0123, "R3 offset ignored");
      step();
      chk("R2 idle after response", 64'({rsp_valid, rsp_hit, rsp_miss}), 64'd0);
      look(36'h1_2345_6789, 4'd4, 12'h555, 0, '0, "R4 other asid");
      look(36'h1_2345_678A, 4'd3, 12'h555, 0, '0, "R4 other vpn");
   endtask

   task automatic t_overwrite();
      inv(2'd0, 0, 0, 0);
      for (int i = 0; i < N; i++) fill(36'(100 + i), 4'd1, pf(i));
      fill(36'd100, 4'd1, 40'h55_6666_7777);
      look(36'd100, 4'd1, 12'h010, 1, 40'h55_6666_7777, "R5 rewritten frame");
      for (int i = 1; i < N; i++) look(36'(100 + i), 4'd1, 12'h020, 1, pf(i), "R5 others kept");
   endtask

   task automatic t_lru();
      inv(2'd0, 0, 0, 0);
      for (int i = 0; i < N; i++) fill(36'(200 + i), 4'd2, pf(i));
      look(36'd200, 4'd2, 12'h0, 1, pf(0), "R7 touch oldest");
      fill(36'd299, 4'd2, pf(9));
      look(36'd201, 4'd2, 12'h0, 0, '0, "R7 lru evicted");
      look(36'd200, 4'd2, 12'h0, 1, pf(0), "R7 touched kept");
      for (int i = 2; i < N; i++) look(36'(200 + i), 4'd2, 12'h0, 1, pf(i), "R7 kept");
      look(36'd299, 4'd2, 12'h0, 1, pf(9), "R7 new entry");
   endtask

   task automatic t_free();
      inv(2'd0, 0, 0, 0);
      for (int i = 0; i < N; i++) fill(36'(300 + i), 4'd5, pf(i));
      inv(2'd2, 0, 36'd301, 36'd301);
      look(36'd301, 4'd5, 12'h0, 0, '0, "R6 freed slot");
      fill(36'd399, 4'd5, pf(7));
      look(36'd300, 4'd5, 12'h0, 1, pf(0), "R6 lru kept");
      for (int i = 2; i < N; i++) look(36'(300 + i), 4'd5, 12'h0, 1, pf(i), "R6 kept");
      look(36'd399, 4'd5, 12'h0, 1, pf(7), "R6 filled free");
   endtask

   task automatic t_asid();
      inv(2'd0, 0, 0, 0);
      fill(36'd10, 4'd1, pf(1)); fill(36'd11, 4'd2, pf(2));
      fill(36'd12, 4'd1, pf(3)); fill(36'd13, 4'd3, pf(4));
      inv(2'd1, 4'd1, 0, 0);
      look(36'd10, 4'd1, 12'h0, 0, '0, "R9 asid cleared");
      look(36'd12, 4'd1, 12'h0, 0, '0, "R9 asid cleared");
      look(36'd11, 4'd2, 12'h0, 1, pf(2), "R9 other asid kept");
      look(36'd13, 4'd3, 12'h0, 1, pf(4), "R9 other asid kept");
   endtask

   task automatic t_range();
      inv(2'd0, 0, 0, 0);
      fill(36'h8_0000_0010, 4'd1, pf(1)); fill(36'h8_0000_0011, 4'd2, pf(2));
      fill(36'h8_0000_0012, 4'd3, pf(3)); fill(36'h8_0000_0013, 4'd1, pf(4));
      inv(2'd2, 4'd9, 36'h8_0000_0011, 36'h8_0000_0012);
      look(36'h8_0000_0010, 4'd1, 12'h0, 1, pf(1), "R10 below range kept");
      look(36'h8_0000_0011, 4'd2, 12'h0, 0, '0, "R10 low bound cleared");
      look(36'h8_0000_0012, 4'd3, 12'h0, 0, '0, "R10 high bound cleared");
      look(36'h8_0000_0013, 4'd1, 12'h0, 1, pf(4), "R10 above range kept");
   endtask

   task automatic t_global();
      inv(2'd0, 0, 0, 0);
      fill(36'd40, 4'd1, pf(1)); fill(36'd41, 4'd7, pf(2));
      inv(2'd3, 4'd1, 36'd0, 36'hF_FFFF_FFFF);
      look(36'd40, 4'd1, 12'h0, 1, pf(1), "R8 code 3 no effect");
      inv(2'd0, 0, 0, 0);
      look(36'd40, 4'd1, 12'h0, 0, '0, "R8 flush all");
      look(36'd41, 4'd7, 12'h0, 0, '0, "R8 flush all");
   endtask

   task automatic t_collide();
      inv(2'd0, 0, 0, 0);
      fill_valid = 1; fill_vpn = 36'd50; fill_asid = 4'd2; fill_pfn = pf(5);
      inv_valid = 1; inv_kind = 2'd2; inv_lo = 36'd900; inv_hi = 36'd901;
      step();
      fill_valid = 0; inv_valid = 0;
      look(36'd50, 4'd2, 12'h0, 0, '0, "R11 fill dropped");
   endtask

   task automatic t_same();
      inv(2'd0, 0, 0, 0);
      fill_valid = 1; fill_vpn = 36'd60; fill_asid = 4'd6; fill_pfn = pf(6);
      look(36'd60, 4'd6, 12'h0, 0, '0, "R12 pre-fill view");
      fill_valid = 0;
      look(36'd60, 4'd6, 12'h0, 1, pf(6), "R12 visible after");
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset(); t_basic(); t_overwrite(); t_lru(); t_free();
      t_asid(); t_range(); t_global(); t_collide(); t_same();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         vectors++; miscompares++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule